// File: doc/BRIEF.md
# Wide Neighbor Gather Aggregator

This block performs the aggregation step of graph message passing. A vertex request names a run of entries in an on-chip neighbor list buffer: a start offset and a degree. The block turns up to 32 of those entries into 32 feature-memory addresses in one cycle. It reads the 32 returned feature words in that same cycle and reduces them with the operation the current layer selects. A vertex with more than 32 neighbors is handled in successive passes over the list, and the passes fold into one running result.

Neighbor indices travel on a narrow integer path, apart from the signed fixed-point feature path. The list buffer is filled through a simple write port before the requests that use it are issued. The reduction is chosen by a configuration input: sum, max or mean. The block samples it when it accepts a request, so software does not step in between layers. The result leaves on a valid/ready output and is held under back-pressure.

Top module: `wide_gather_agg`

## Requirements
- R1: After reset, req_ready is 1 and out_valid is 0.
- R2: A request of degree 1 to 32 in sum or max mode is gathered in a single pass. out_valid is 1 in the cycle after the first clock edge that follows the accepting edge.
- R3: A request of degree d above 32 takes ceil(d/32) gather passes, one per clock. In sum and max mode, out_valid rises after that many edges beyond the accepting edge.
- R4: cfg_mode 0 (and the unused code 3) selects sum. The result is the exact sum of the neighbors' signed 16-bit features, clamped to the range -32768 to 32767.
- R5: cfg_mode 1 selects max. The result is the largest signed feature among the neighbors.
- R6: cfg_mode 2 selects mean. The result is the exact sum divided by the degree and truncated toward zero. The division is sequential and adds 24 clock edges after the last pass.
- R7: Lanes at or beyond the degree contribute nothing. Neighbor list entries past start+degree-1 do not affect the result.
- R8: A request of degree 0 produces exactly one output beat with value 0 in every mode. out_valid rises one edge after acceptance.
- R9: The reduction mode is captured when a request is accepted. Changes to cfg_mode while that request is in flight do not alter its result.
- R10: While out_valid is 1 and out_ready is 0, out_valid and out_data hold. After the handshake edge, out_valid is 0 and req_ready is 1.
- R11: Lane j of pass k reads neighbor list entry (start + 32k + j) mod 256 and presents it on fm_addr bits [8j+7:8j]. The returned feature word arrives on fm_data bits [16j+15:16j] in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 2 | Reduction select: 0 sum, 1 max, 2 mean, 3 sum |
| nl_we | input | 1 | Neighbor list buffer write enable |
| nl_waddr | input | 8 | Neighbor list buffer write address |
| nl_wdata | input | 8 | Neighbor index to store |
| req_valid | input | 1 | Vertex request valid |
| req_ready | output | 1 | Block can accept a request |
| req_start | input | 8 | First neighbor list entry of the vertex |
| req_degree | input | 8 | Number of neighbors |
| fm_addr | output | 256 | 32 feature read addresses, 8 bits each |
| fm_data | input | 512 | 32 feature words, signed 16 bits each |
| out_valid | output | 1 | Aggregated result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 16 | Aggregated signed feature |

## Verification
A wrong pass counter or lane mask shows up at the ports as a result that takes in too many or too few neighbors. It also shows as a valid that rises a pass early or late, so the bench checks out_valid against the expected latency on every clock and sees the error in the first cycle it occurs. A mode captured at the wrong time, or a divider that is off by a step, yields a wrong value on the single output beat of that vertex. Large same-sign neighborhoods drive the clamp, and masked list entries point at extreme features, so leakage from masked lanes changes the value at once.

// File: rtl/wide_gather_agg.sv
module wide_gather_agg #(
  parameter int LANES = 32,
  parameter int FW    = 16,
  parameter int IW    = 8,
  parameter int NAW   = 8,
  parameter int DW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_mode,
  input  logic                  nl_we,
  input  logic [NAW-1:0]        nl_waddr,
  input  logic [IW-1:0]         nl_wdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [NAW-1:0]        req_start,
  input  logic [DW-1:0]         req_degree,
  output logic [LANES*IW-1:0]   fm_addr,
  input  logic [LANES*FW-1:0]   fm_data,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [FW-1:0]         out_data
);
  localparam int ACW = FW + DW;
  localparam int NLD = 2 ** NAW;
  localparam logic signed [ACW-1:0] MAXV = ACW'((1 << (FW-1)) - 1);
  localparam logic signed [ACW-1:0] MINV = -MAXV - 1;

  typedef enum logic [1:0] {S_IDLE, S_GATH, S_DIV, S_OUT} st_t;
  st_t st;

  logic [IW-1:0]         nlb [NLD];
  logic [1:0]            mode_q;
  logic [NAW-1:0]        start_q;
  logic [DW-1:0]         deg_q;
  logic [DW:0]           pbase, remaining;
  logic signed [ACW-1:0] acc, acc_next, psum, pmax, v, mag, satv;
  logic [ACW-1:0]        dvd, quo, qn;
  logic [DW:0]           rem;
  logic [DW+1:0]         r2, d2;
  logic                  ge, neg, last, first;
  logic [$clog2(ACW+1)-1:0] dcnt;

  assign req_ready = (st == S_IDLE);
  assign out_valid = (st == S_OUT);
  assign remaining = {1'b0, deg_q} - pbase;
  assign last      = remaining <= (DW+1)'(LANES);
  assign first     = (pbase == '0);

  always_ff @(posedge clk)
    if (nl_we) nlb[nl_waddr] <= nl_wdata;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign fm_addr[j*IW +: IW] = nlb[start_q + pbase[NAW-1:0] + NAW'(j)];
  end

  always_comb begin
    psum = '0;
    pmax = MINV;
    v    = '0;
    for (int j = 0; j < LANES; j++) begin
      if ((DW+1)'(j) < remaining) begin
        v = {{DW{fm_data[j*FW+FW-1]}}, fm_data[j*FW +: FW]};
        psum = psum + v;
        if (v > pmax) pmax = v;
      end
    end
    if (mode_q == 2'd1) acc_next = (first || pmax > acc) ? pmax : acc;
    else                acc_next = first ? psum : acc + psum;
    mag  = acc_next[ACW-1] ? -acc_next : acc_next;
    satv = (acc_next > MAXV) ? MAXV : (acc_next < MINV) ? MINV : acc_next;
  end

  assign r2 = {rem, dvd[ACW-1]};
  assign d2 = (DW+2)'(deg_q);
  assign ge = r2 >= d2;
  assign qn = {quo[ACW-2:0], ge};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; out_data <= '0; pbase <= '0; acc <= '0;
      mode_q <= '0; start_q <= '0; deg_q <= '0;
      dvd <= '0; quo <= '0; rem <= '0; neg <= 1'b0; dcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          mode_q <= cfg_mode; start_q <= req_start; deg_q <= req_degree;
          pbase <= '0; st <= S_GATH;
        end
        S_GATH: begin
          acc   <= acc_next;
          pbase <= pbase + (DW+1)'(LANES);
          if (last) begin
            if (deg_q == '0) begin
              out_data <= '0; st <= S_OUT;
            end else if (mode_q == 2'd2) begin
              dvd <= mag; quo <= '0; rem <= '0; neg <= acc_next[ACW-1];
              dcnt <= ($clog2(ACW+1))'(ACW); st <= S_DIV;
            end else begin
              out_data <= (mode_q == 2'd1) ? acc_next[FW-1:0] : satv[FW-1:0];
              st <= S_OUT;
            end
          end
        end
        S_DIV: begin
          rem  <= (DW+1)'(ge ? r2 - d2 : r2);
          dvd  <= dvd << 1;
          quo  <= qn;
          dcnt <= dcnt - 1'b1;
          if (dcnt == 1) begin
            out_data <= FW'(neg ? -qn : qn);
            st <= S_OUT;
          end
        end
        default: if (out_ready) st <= S_IDLE;
      endcase
    end
  end

  // R2
  single_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_degree != '0 && req_degree <= DW'(LANES) && cfg_mode != 2'd2)
    |-> ##2 out_valid);

  // R8
  zero_degree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_degree == '0) |-> ##2 (out_valid && out_data == '0));

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  out_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (req_ready && !out_valid));
endmodule

// File: tb/tb_wide_gather_agg.sv
module tb_wide_gather_agg;
  localparam int CLK_PERIOD = 10;
  localparam int DIVLAT = 24;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_mode = 0;
  logic nl_we = 0;
  logic [7:0] nl_waddr = 0, nl_wdata = 0;
  logic req_valid = 0, req_ready;
  logic [7:0] req_start = 0, req_degree = 0;
  logic [255:0] fm_addr;
  logic [511:0] fm_data;
  logic out_valid, out_ready = 1;
  logic [15:0] out_data;

  logic signed [15:0] feat [256];
  int nl [256];
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int j = 0; j < 32; j++) fm_data[j*16 +: 16] = feat[fm_addr[j*8 +: 8]];

  wide_gather_agg dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nl_write(input int a, input int d);
    @(negedge clk); nl_we = 1; nl_waddr = 8'(a); nl_wdata = 8'(d); nl[a] = d;
    @(posedge clk); #1 nl_we = 0;
  endtask

  task automatic run(input int st, input int dg, input int md, input int stall, input string tag);
    int sum = 0, mx = -32768, exp, p, lat;
    for (int i = 0; i < dg; i++) begin
      int f = feat[nl[(st + i) % 256]];
      sum += f;
      if (f > mx) mx = f;
    end
    if (dg == 0) exp = 0;
    else if (md == 1) exp = mx;
    else if (md == 2) exp = sum / dg;
    else exp = (sum > 32767) ? 32767 : (sum < -32768) ? -32768 : sum;
    p = (dg == 0) ? 1 : (dg + 31) / 32;
    lat = p + ((md == 2 && dg != 0) ? DIVLAT : 0);
    @(negedge clk);
    check({tag, " R10 req_ready idle"}, int'(req_ready), 1);
    req_valid = 1; req_start = 8'(st); req_degree = 8'(dg); cfg_mode = 2'(md);
    @(posedge clk);
    for (int k = 0; k < lat; k++) begin
      @(negedge clk);
      if (k == 0) begin req_valid = 0; cfg_mode = 2'((md + 1) % 3); end
      check({tag, " early valid"}, int'(out_valid), 0);
      @(posedge clk);
    end
    @(negedge clk);
    check({tag, " valid at latency"}, int'(out_valid), 1);
    check({tag, " data"}, int'($signed(out_data)), exp);
    if (stall > 0) out_ready = 0;
    for (int s = 0; s < stall; s++) begin
      @(posedge clk); @(negedge clk);
      check({tag, " R10 hold valid"}, int'(out_valid), 1);
      check({tag, " R10 hold data"}, int'($signed(out_data)), exp);
    end
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    check({tag, " R10 released"}, int'(out_valid), 0);
    check({tag, " R10 ready again"}, int'(req_ready), 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) feat[i] = 16'(((i * 7919 + 13) % 2001) - 1000);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 req_ready after reset", int'(req_ready), 1);
    check("R1 out_valid after reset", int'(out_valid), 0);
    for (int i = 0; i < 256; i++) nl_write(i, (i * 37 + 5) % 256);

    run(10, 5,  0, 0, "R2 R4 R11 sum deg5");
    run(40, 32, 0, 2, "R2 R4 sum deg32");
    run(0,  33, 0, 0, "R3 R4 sum deg33");
    run(7, 100, 0, 1, "R3 R4 sum deg100");
    run(1, 255, 0, 0, "R3 R4 sum deg255");
    run(3,  17, 1, 0, "R2 R5 max deg17");
    run(90, 64, 1, 3, "R3 R5 max deg64");
    run(20,  7, 2, 0, "R6 mean deg7");
    run(50, 70, 2, 1, "R3 R6 mean deg70");
    run(5,   0, 0, 0, "R8 deg0 sum");
    run(5,   0, 1, 0, "R8 deg0 max");
    run(5,   0, 2, 0, "R8 deg0 mean");
    run(8,  20, 3, 0, "R4 R9 code3 sum");

    // R7: masked entries point at an extreme feature
    feat[255] = 16'sd32767;
    for (int i = 0; i < 4; i++) feat[200 + i] = 16'(-100 - 10 * i);
    for (int i = 0; i < 4; i++) nl_write(100 + i, 200 + i);
    for (int i = 4; i < 32; i++) nl_write(100 + i, 255);
    run(100, 4, 1, 0, "R7 max masked lanes");
    run(100, 4, 0, 0, "R7 sum masked lanes");
    run(100, 4, 2, 0, "R7 R6 mean negative");

    // R4 clamp both directions
    for (int i = 0; i < 40; i++) feat[150 + i] = 16'sd30000;
    for (int i = 0; i < 40; i++) nl_write(i, 150 + i);
    run(0, 40, 0, 0, "R4 positive clamp");
    run(0, 40, 2, 0, "R6 mean large");
    for (int i = 0; i < 40; i++) feat[150 + i] = -16'sd30000;
    run(0, 40, 0, 0, "R4 negative clamp");
    run(0, 40, 1, 1, "R5 R9 max all equal");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule